// File: doc/BRIEF.md
# Tagged Branch History Table

This block is a small, fully associative predictor that sits beside instruction fetch. Every cycle the fetch address is compared against the address tags of all entries at once. A matching entry supplies a hit flag, a taken or not-taken prediction and the target it recorded earlier. The block also gives the address fetch should use next. On a predicted-taken hit this is the stored target, so the redirect needs no address arithmetic. In every other case it is the sequential address.

Resolved branches come back from the execute stage on an update port, which carries the branch address, the actual direction and the actual target. If an entry holds that address, its target is rewritten and its two-bit prediction state moves one step. If no entry holds it, the slot named by a round-robin pointer is overwritten with a fresh entry. Each entry's two-bit state gives the direction hysteresis: one wrong guess from a confident state does not reverse the prediction.

The state machine per entry has four states. Their names and encodings are PRED_NT_STRONG = 00, PRED_NT_WEAK = 01, PRED_T_WEAK = 10 and PRED_T_STRONG = 11. The transitions are these:
- A correct outcome in a weak state promotes it to the strong state of the same direction.
- A correct outcome in a strong state keeps it there.
- A wrong outcome in a strong state demotes it to the weak state of the same direction.
- A wrong outcome in a weak state jumps to the strong state of the opposite direction.

Top module: `tagged_bht`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an update has been applied.
- R2: A lookup hits when a valid entry's tag equals the fetch address. All entries are compared in the same cycle, and at most one entry ever matches a given address.
- R3: On a hit, the predicted direction is bit 1 of the entry's state (1 = taken), and the returned target is the entry's stored target.
- R4: The next fetch address is the stored target on a hit predicting taken. Otherwise it is the fetch address plus INSTR_STEP (default 4).
- R5: An update whose address matches no entry allocates the slot at the round-robin pointer. The new entry stores the address as its tag and the resolved target. Its state is PRED_T_WEAK (10) if the branch was taken and PRED_NT_WEAK (01) if not.
- R6: An update that hits moves the entry's state by the transitions listed above. As a result, a single wrong outcome from a strong state keeps the predicted direction, and a second consecutive wrong outcome reverses it.
- R7: An update that hits rewrites the entry's stored target with the resolved target.
- R8: Updates take effect at the clock edge. A lookup in the same cycle as an update to the same entry returns the state and target from before the update.
- R9: The round-robin pointer starts at slot 0 and advances by one, wrapping at ENTRIES, on each allocation only. The (ENTRIES+1)-th distinct allocation therefore evicts the first allocated address.
- R10: While the update-valid input is low, the update inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | ADDR_W | Fetch address being looked up |
| lkp_hit | output | 1 | A valid entry matches lkp_pc |
| lkp_taken | output | 1 | Predicted taken (0 on a miss) |
| lkp_target | output | ADDR_W | Stored target of the matching entry (0 on a miss) |
| fetch_next | output | ADDR_W | Address fetch should use next |
| upd_valid | input | 1 | Resolved-branch update present |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | ADDR_W | Actual target |

## Verification
The assertions check several properties on every cycle:
- No fetch address ever matches more than one entry.
- A miss never predicts taken.
- The next-fetch address always follows the hit and direction outputs.
- The round-robin pointer moves only on allocating updates, by exactly one slot.

Some behaviours need history, and only the bench scenarios can show them. These are the two-miss hysteresis, the weak initial state after allocation, the eviction order, target rewrites, and the old-value visibility of a lookup in the same cycle as an update. The bench shows them by comparing every lookup against an arithmetic model of the table across a long mixed update stream.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        PRED_NT_STRONG = 2'b00,
        PRED_NT_WEAK   = 2'b01,
        PRED_T_WEAK    = 2'b10,
        PRED_T_STRONG  = 2'b11
    } pred_state_e;

endpackage

// File: rtl/bht_entry.sv
module bht_entry
    import bht_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_we,
    input  logic              hit_we,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    output logic              ent_valid,
    output logic [ADDR_W-1:0] ent_tag,
    output logic [ADDR_W-1:0] ent_target,
    output logic              ent_pred_taken
);

    pred_state_e state_q, state_d;

    // Transition of the two-bit predictor on a resolved outcome
    always_comb begin
        state_d = state_q;
        if (alloc_we) begin
            state_d = wr_taken ? PRED_T_WEAK : PRED_NT_WEAK;
        end else if (hit_we) begin
            unique case (state_q)
                PRED_NT_STRONG: state_d = wr_taken ? PRED_NT_WEAK  : PRED_NT_STRONG;
                PRED_NT_WEAK:   state_d = wr_taken ? PRED_T_STRONG : PRED_NT_STRONG;
                PRED_T_WEAK:    state_d = wr_taken ? PRED_T_STRONG : PRED_NT_STRONG;
                PRED_T_STRONG:  state_d = wr_taken ? PRED_T_STRONG : PRED_T_WEAK;
                default:        state_d = PRED_NT_WEAK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PRED_NT_WEAK;
            ent_valid  <= 1'b0;
            ent_tag    <= '0;
            ent_target <= '0;
        end else begin
            state_q <= state_d;
            if (alloc_we) begin
                ent_valid  <= 1'b1;
                ent_tag    <= wr_tag;
                ent_target <= wr_target;
            end else if (hit_we) begin
                ent_target <= wr_target;
            end
        end
    end

    always_comb ent_pred_taken = state_q[1];

endmodule

// File: rtl/bht_rr_ptr.sv
module bht_rr_ptr #(
    parameter int ENTRIES = 4,
    parameter int PTR_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tagged_bht.sv
module tagged_bht #(
    parameter int ADDR_W     = 16,
    parameter int ENTRIES    = 4,
    parameter int INSTR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lkp_pc,
    output logic              lkp_hit,
    output logic              lkp_taken,
    output logic [ADDR_W-1:0] lkp_target,
    output logic [ADDR_W-1:0] fetch_next,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_pred;
    logic [ADDR_W-1:0]  ent_tag    [ENTRIES];
    logic [ADDR_W-1:0]  ent_target [ENTRIES];
    logic [ENTRIES-1:0] lkp_match;
    logic [ENTRIES-1:0] upd_match;
    logic               upd_hit;
    logic               alloc;
    logic [PTR_W-1:0]   alloc_ptr;

    always_comb begin
        upd_hit = |upd_match;
        alloc   = upd_valid && !upd_hit;
    end

    bht_rr_ptr #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) rr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (alloc),
        .ptr   (alloc_ptr)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_comb begin
            lkp_match[g] = ent_valid[g] && (ent_tag[g] == lkp_pc);
            upd_match[g] = ent_valid[g] && (ent_tag[g] == upd_pc);
        end

        bht_entry #(.ADDR_W(ADDR_W)) ent_i (
            .clk            (clk),
            .rst_n          (rst_n),
            .alloc_we       (alloc && (alloc_ptr == PTR_W'(g))),
            .hit_we         (upd_valid && upd_match[g]),
            .wr_taken       (upd_taken),
            .wr_tag         (upd_pc),
            .wr_target      (upd_target),
            .ent_valid      (ent_valid[g]),
            .ent_tag        (ent_tag[g]),
            .ent_target     (ent_target[g]),
            .ent_pred_taken (ent_pred[g])
        );
    end

    // Parallel compare result folded into one read port
    always_comb begin
        lkp_hit    = 1'b0;
        lkp_taken  = 1'b0;
        lkp_target = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lkp_match[i]) begin
                lkp_hit    = 1'b1;
                lkp_taken  = ent_pred[i];
                lkp_target = ent_target[i];
            end
        end
        fetch_next = (lkp_hit && lkp_taken) ? lkp_target
                                            : lkp_pc + ADDR_W'(INSTR_STEP);
    end

endmodule

// File: rtl/bht_chk.sv
module bht_chk #(
    parameter int ADDR_W     = 16,
    parameter int ENTRIES    = 4,
    parameter int PTR_W      = 2,
    parameter int INSTR_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lkp_pc,
    input logic              lkp_hit,
    input logic              lkp_taken,
    input logic [ADDR_W-1:0] lkp_target,
    input logic [ADDR_W-1:0] fetch_next,
    input logic              upd_valid,
    input logic              upd_hit,
    input logic [PTR_W-1:0]  alloc_ptr,
    input logic [ENTRIES-1:0] lkp_match
);

    // R2
    unique_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lkp_match));

    // R3
    miss_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_hit |-> !lkp_taken);

    // R4
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_hit && lkp_taken) |-> (fetch_next == lkp_target));

    // R4
    sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lkp_hit && lkp_taken) |-> (fetch_next == lkp_pc + ADDR_W'(INSTR_STEP)));

    // R9
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_hit) |=> (alloc_ptr ==
            (($past(alloc_ptr) == PTR_W'(ENTRIES - 1)) ? '0 : $past(alloc_ptr) + 1'b1)));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && !upd_hit) |=> $stable(alloc_ptr));

endmodule

bind tagged_bht bht_chk #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .PTR_W(PTR_W), .INSTR_STEP(INSTR_STEP)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lkp_pc     (lkp_pc),
    .lkp_hit    (lkp_hit),
    .lkp_taken  (lkp_taken),
    .lkp_target (lkp_target),
    .fetch_next (fetch_next),
    .upd_valid  (upd_valid),
    .upd_hit    (upd_hit),
    .alloc_ptr  (alloc_ptr),
    .lkp_match  (lkp_match)
);

// File: tb/tagged_bht_tb_top.sv
`timescale 1ns/1ps
module tagged_bht_tb_top;

    localparam int AW = 16;
    localparam int NE = 4;
    localparam int STEP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lkp_pc = '0;
    logic          lkp_hit, lkp_taken;
    logic [AW-1:0] lkp_target, fetch_next;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model of the table, built from the requirements
    bit            m_valid [NE];
    logic [AW-1:0] m_tag   [NE];
    logic [AW-1:0] m_tgt   [NE];
    int            m_st    [NE];
    int            m_ptr;

    always #2.5 clk = ~clk;

    tagged_bht #(.ADDR_W(AW), .ENTRIES(NE), .INSTR_STEP(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_hit(lkp_hit),
        .lkp_taken(lkp_taken), .lkp_target(lkp_target), .fetch_next(fetch_next),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target)
    );

    function automatic int next_st(int s, bit t);
        case (s)
            0: return t ? 1 : 0;
            1: return t ? 3 : 0;
            2: return t ? 3 : 0;
            default: return t ? 3 : 2;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NE; i++) begin
            m_valid[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_st[i] = 1;
        end
        m_ptr = 0;
    endtask

    task automatic model_update(logic [AW-1:0] pc, bit t, logic [AW-1:0] tg);
        int hit_i = -1;
        for (int i = 0; i < NE; i++)
            if (m_valid[i] && m_tag[i] == pc) hit_i = i;
        if (hit_i >= 0) begin
            m_st[hit_i]  = next_st(m_st[hit_i], t);
            m_tgt[hit_i] = tg;
        end else begin
            m_valid[m_ptr] = 1; m_tag[m_ptr] = pc; m_tgt[m_ptr] = tg;
            m_st[m_ptr] = t ? 2 : 1;
            m_ptr = (m_ptr + 1) % NE;
        end
    endtask

    // drive lookup, compare all outputs against the model
    task automatic check_pc(logic [AW-1:0] pc, string req);
        bit e_hit = 0, e_tk = 0;
        logic [AW-1:0] e_tg = '0, e_nx;
        lkp_pc = pc;
        #1;
        for (int i = 0; i < NE; i++)
            if (m_valid[i] && m_tag[i] == pc) begin
                e_hit = 1; e_tk = (m_st[i] >= 2); e_tg = m_tgt[i];
            end
        e_nx = (e_hit && e_tk) ? e_tg : pc + AW'(STEP);
        n_chk++;
        if (lkp_hit !== e_hit || lkp_taken !== e_tk || lkp_target !== e_tg
            || fetch_next !== e_nx) begin
            n_bad++;
            $display("FAIL %s pc=%h got hit=%b tk=%b tg=%h nx=%h exp hit=%b tk=%b tg=%h nx=%h",
                     req, pc, lkp_hit, lkp_taken, lkp_target, fetch_next,
                     e_hit, e_tk, e_tg, e_nx);
        end
    endtask

    task automatic do_update(logic [AW-1:0] pc, bit t, logic [AW-1:0] tg);
        upd_valid = 1; upd_pc = pc; upd_taken = t; upd_target = tg;
        @(posedge clk);
        model_update(pc, t, tg);
        @(negedge clk);
        upd_valid = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic [AW-1:0] pcs [6];
        model_reset();
        pcs[0] = 16'h0100; pcs[1] = 16'h0204; pcs[2] = 16'h0308;
        pcs[3] = 16'h040C; pcs[4] = 16'h0510; pcs[5] = 16'h0614;
        repeat (3) @(negedge clk);
        // R1: reset state, every lookup misses
        for (int i = 0; i < 6; i++) check_pc(pcs[i], "R1");
        rst_n = 1;
        @(negedge clk);
        check_pc(pcs[0], "R1");

        // R5: allocation in weak taken, then R6 hysteresis
        do_update(pcs[0], 1, 16'h1000);
        check_pc(pcs[0], "R5");
        do_update(pcs[0], 1, 16'h1000);   // strong taken
        check_pc(pcs[0], "R6");
        do_update(pcs[0], 0, 16'h1000);   // one miss: still taken
        check_pc(pcs[0], "R6");
        do_update(pcs[0], 0, 16'h1000);   // second miss: flips
        check_pc(pcs[0], "R6");
        // R5: not-taken allocation
        do_update(pcs[1], 0, 16'h2000);
        check_pc(pcs[1], "R5");
        // R7: target rewrite on hit
        do_update(pcs[0], 1, 16'h1234);
        do_update(pcs[0], 1, 16'h4321);
        check_pc(pcs[0], "R7");

        // R8: same-cycle lookup sees old contents
        upd_valid = 1; upd_pc = pcs[0]; upd_taken = 0; upd_target = 16'h5555;
        check_pc(pcs[0], "R8");
        @(posedge clk);
        model_update(pcs[0], 0, 16'h5555);
        @(negedge clk);
        upd_valid = 0;
        check_pc(pcs[0], "R8");

        // R10: update inputs without valid do nothing
        upd_valid = 0; upd_pc = pcs[0]; upd_taken = 1; upd_target = 16'h7777;
        @(posedge clk); @(negedge clk);
        upd_pc = pcs[5];
        @(posedge clk); @(negedge clk);
        check_pc(pcs[0], "R10");
        check_pc(pcs[5], "R10");

        // R9: fill remaining slots, the next allocation evicts pcs[0]
        do_update(pcs[2], 1, 16'h3000);
        do_update(pcs[3], 1, 16'h3100);
        do_update(pcs[4], 1, 16'h3200);
        check_pc(pcs[0], "R9");
        check_pc(pcs[1], "R9");
        check_pc(pcs[4], "R9");

        // R2 R3 R4: long mixed sweep, every candidate address checked after each update
        for (int k = 0; k < 400; k++) begin
            int sel;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel = int'(lfsr[2:0]) % 6;
            do_update(pcs[sel], lfsr[5], {lfsr[15:4], 4'h0});
            for (int i = 0; i < 6; i++) check_pc(pcs[i], "R3");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule